// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block drives one compare output pin from an externally supplied timer count and two compare values, called A and B here. A 3-bit mode code chooses how the pin reacts to matches: off, a one-shot edge that sets or clears the pin, a toggle on every A match, a single pulse or a repeating pulse bounded by A and B matches, or pulse-width modulation aligned to the period edge or centred in it.

Software programs the channel through a small register write port. Address 0 holds the control word. Address 1 holds compare value A. Address 2 holds compare value B. A write to address 3 is ignored.

The control word also carries the following fields:
- a fault enable bit for the two PWM modes;
- a strobe bit that clears the sticky fault flag;
- a strobe bit that clears the trigger flag;
- an auto-clear bit that lets a B match clear the trigger flag.

The trigger flag is set by an external trigger input. The timer, interrupt generation and pin routing live outside the block.

Top module: `oc_channel`

## Requirements
- R1: After reset, `oc_out`, `fault_stat` and `trig_stat` are all 0.
- R2: With mode 000, `oc_out` stays 0 whatever the timer does, and `fault_stat` does not set.
- R3: The control word sits at address 0, with bits [2:0] holding the mode. Writing mode 001 makes the registered output 0. The first clock edge at which the timer equals A (address 1) drives it to 1, and it then holds at 1.
- R4: Writing mode 010 makes the output 1. The first clock edge at which the timer equals A drives it to 0, and it then holds at 0.
- R5: In mode 011, the output inverts at every clock edge where the timer equals A. Its initial level after the mode write is 0.
- R6: Mode 100 starts low. The output rises at the first A match and falls at the next B match (address 2). After that it stays low until the control word is written again.
- R7: Mode 101 starts low. The output rises on an A match and falls on the following B match, and this repeats without end.
- R8: Mode 110 (edge-aligned PWM) starts low. A B match, which ends the period, drives the output to 1. An A match drives it to 0. When both match at once, the output goes to 0.
- R9: Mode 111 (center-aligned PWM) starts low. An A match drives the output to 1. A B match drives it to 0. When both match at once, the output goes to 0.
- R10: The fault enable is control bit 4. In modes 110 and 111 with fault enable set, a high `fault_in` forces `oc_out` low in the same cycle and sets `fault_stat` at the next edge. `fault_stat` stays set, and the output stays low, until a control write with bit 5 set clears it. If the fault is still present during that write, the set wins.
- R11: In modes other than 110 and 111, `fault_in` has no effect on `oc_out` and never sets `fault_stat`.
- R12: Every write to the control word resets the one-shot state and the output level of the selected mode, so rewriting a one-shot mode re-arms it.
- R13: A high `trig_in` sets `trig_stat` at the next edge, and a set takes priority over any clear in the same cycle. `trig_stat` clears when software writes the control word with bit 6 set. It also clears at an edge where the timer equals B, but only if control bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare A, 2 compare B |
| wr_data | input | TW | Write data |
| tmr | input | TW | Timer count |
| fault_in | input | 1 | Fault input, active high |
| trig_in | input | 1 | Trigger input, sets the trigger flag |
| oc_out | output | 1 | Compare output pin |
| fault_stat | output | 1 | Sticky fault flag |
| trig_stat | output | 1 | Trigger flag |

## Verification
The bench builds the channel with TW = 8. With an 8-bit width, the timer can be swept through short, hand-chosen sequences that hit A, B and non-matching values in any order, including wrapping back to an earlier match. This is enough to show that each one-shot mode fires once and then holds, and that the repeating modes fire again. Value 0xFF is kept as a parking count that matches neither compare register during register writes. This keeps each write's effect on the output separate from any match effect.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic [TW-1:0] tmr,
  input  logic          fault_in,
  input  logic          trig_in,
  output logic          oc_out,
  output logic          fault_stat,
  output logic          trig_stat
);

  localparam logic [2:0] M_OFF = 3'b000, M_SET1 = 3'b001, M_CLR1 = 3'b010, M_TOG = 3'b011,
                         M_PUL1 = 3'b100, M_PULC = 3'b101, M_EPWM = 3'b110, M_CPWM = 3'b111;

  logic [2:0]    mode;
  logic          trig_auto, fault_en;
  logic [TW-1:0] cmp_a, cmp_b;
  logic          oc_q, done, phase;

  wire ctrl_wr   = wr_en && (wr_addr == 2'd0);
  wire hit_a     = (tmr == cmp_a);
  wire hit_b     = (tmr == cmp_b);
  wire pwm       = mode[2] & mode[1];
  wire fault_now = pwm & fault_en & fault_in;
  wire fault_clr = ctrl_wr & wr_data[5];
  wire trig_clr  = ctrl_wr & wr_data[6];

  assign oc_out = oc_q & ~(pwm & fault_en & (fault_in | fault_stat));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_OFF;
      trig_auto <= 1'b0;
      fault_en  <= 1'b0;
      cmp_a     <= '0;
      cmp_b     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          mode      <= wr_data[2:0];
          trig_auto <= wr_data[3];
          fault_en  <= wr_data[4];
        end
        2'd1: cmp_a <= wr_data;
        2'd2: cmp_b <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_q  <= 1'b0;
      done  <= 1'b0;
      phase <= 1'b0;
    end else if (ctrl_wr) begin
      oc_q  <= (wr_data[2:0] == M_CLR1);
      done  <= 1'b0;
      phase <= 1'b0;
    end else begin
      case (mode)
        M_SET1: if (!done && hit_a) begin oc_q <= 1'b1; done <= 1'b1; end
        M_CLR1: if (!done && hit_a) begin oc_q <= 1'b0; done <= 1'b1; end
        M_TOG:  if (hit_a) oc_q <= ~oc_q;
        M_PUL1, M_PULC: begin
          if (!done) begin
            if (!phase) begin
              if (hit_a) begin oc_q <= 1'b1; phase <= 1'b1; end
            end else if (hit_b) begin
              oc_q  <= 1'b0;
              phase <= 1'b0;
              done  <= (mode == M_PUL1);
            end
          end
        end
        M_EPWM: if (hit_a) oc_q <= 1'b0; else if (hit_b) oc_q <= 1'b1;
        M_CPWM: if (hit_b) oc_q <= 1'b0; else if (hit_a) oc_q <= 1'b1;
        default: oc_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_stat <= 1'b0;
      trig_stat  <= 1'b0;
    end else begin
      fault_stat <= fault_now | (fault_stat & ~fault_clr);
      trig_stat  <= trig_in | (trig_stat & ~trig_clr & ~(trig_auto & hit_b));
    end
  end

  // R2
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && !ctrl_wr) |=> !oc_out);

  // R3
  set_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SET1 && oc_q && !ctrl_wr) |=> oc_q);

  // R4
  clr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CLR1 && !oc_q && !ctrl_wr) |=> !oc_q);

  // R6
  pulse_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PUL1 && done && !ctrl_wr) |=> !oc_q);

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_stat && !fault_clr) |=> fault_stat);

  // R11
  fault_pwm_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && !fault_stat) |=> !fault_stat);

  // R13
  trig_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_stat && !trig_auto && !trig_clr) |=> trig_stat);

endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [TW-1:0] wr_data = '0;
  logic [TW-1:0] tmr = 8'hFF;
  logic          fault_in = 1'b0;
  logic          trig_in = 1'b0;
  logic          oc_out, fault_stat, trig_stat;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  oc_channel #(.TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr(tmr), .fault_in(fault_in), .trig_in(trig_in),
    .oc_out(oc_out), .fault_stat(fault_stat), .trig_stat(trig_stat)
  );

  always #4 clk = ~clk;

  function automatic logic [TW-1:0] ctl(input logic [2:0] m, input bit aut = 0,
                                         input bit fen = 0, input bit fclr = 0, input bit tclr = 0);
    return {1'b0, tclr, fclr, fen, aut, m};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [TW-1:0] d);
    tmr = 8'hFF; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic [TW-1:0] v);
    tmr = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 oc", oc_out, 1'b0);
    chk("R1 fault", fault_stat, 1'b0);
    chk("R1 trig", trig_stat, 1'b0);
  endtask

  task automatic t_set_once;
    wr(1, 8'd5); wr(0, ctl(3'b001));
    chk("R3 init", oc_out, 1'b0);
    for (int i = 0; i < 5; i++) step(i[TW-1:0]);
    chk("R3 before match", oc_out, 1'b0);
    step(5); chk("R3 match", oc_out, 1'b1);
    step(6); step(5); chk("R3 holds", oc_out, 1'b1);
    wr(0, ctl(3'b001)); chk("R12 rearm low", oc_out, 1'b0);
    step(5); chk("R12 refire", oc_out, 1'b1);
  endtask

  task automatic t_clr_once;
    wr(0, ctl(3'b010)); chk("R4 init", oc_out, 1'b1);
    step(4); chk("R4 no match", oc_out, 1'b1);
    step(5); chk("R4 match", oc_out, 1'b0);
    step(5); chk("R4 holds", oc_out, 1'b0);
  endtask

  task automatic t_toggle;
    wr(0, ctl(3'b011)); chk("R5 init", oc_out, 1'b0);
    step(5); chk("R5 first", oc_out, 1'b1);
    step(6); chk("R5 steady", oc_out, 1'b1);
    step(5); chk("R5 second", oc_out, 1'b0);
  endtask

  task automatic t_pulse_once;
    wr(1, 8'd3); wr(2, 8'd6); wr(0, ctl(3'b100));
    chk("R6 init", oc_out, 1'b0);
    step(3); chk("R6 rise", oc_out, 1'b1);
    step(4); chk("R6 hold", oc_out, 1'b1);
    step(6); chk("R6 fall", oc_out, 1'b0);
    step(3); chk("R6 no repeat", oc_out, 1'b0);
  endtask

  task automatic t_pulse_cont;
    wr(0, ctl(3'b101));
    step(6); chk("R7 B first ignored", oc_out, 1'b0);
    step(3); chk("R7 rise1", oc_out, 1'b1);
    step(6); chk("R7 fall1", oc_out, 1'b0);
    step(3); chk("R7 rise2", oc_out, 1'b1);
    step(6); chk("R7 fall2", oc_out, 1'b0);
  endtask

  task automatic t_edge_pwm;
    wr(1, 8'd2); wr(2, 8'd5); wr(0, ctl(3'b110));
    chk("R8 init", oc_out, 1'b0);
    step(5); chk("R8 period start", oc_out, 1'b1);
    step(0); step(1); chk("R8 high", oc_out, 1'b1);
    step(2); chk("R8 duty end", oc_out, 1'b0);
    step(3); chk("R8 low", oc_out, 1'b0);
    step(5); chk("R8 next period", oc_out, 1'b1);
  endtask

  task automatic t_center_pwm;
    wr(0, ctl(3'b111));
    step(1); chk("R9 init", oc_out, 1'b0);
    step(2); chk("R9 rise", oc_out, 1'b1);
    step(4); chk("R9 hold", oc_out, 1'b1);
    step(5); chk("R9 fall", oc_out, 1'b0);
    step(2); chk("R9 rise again", oc_out, 1'b1);
  endtask

  task automatic t_fault;
    wr(0, ctl(3'b110, 0, 1));
    step(5); chk("R10 running", oc_out, 1'b1);
    fault_in = 1'b1; #1;
    chk("R10 immediate low", oc_out, 1'b0);
    chk("R10 status not yet", fault_stat, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R10 status set", fault_stat, 1'b1);
    fault_in = 1'b0;
    step(5); chk("R10 held low", oc_out, 1'b0);
    chk("R10 sticky", fault_stat, 1'b1);
    wr(0, ctl(3'b110, 0, 1, 1));
    chk("R10 cleared", fault_stat, 1'b0);
    step(5); chk("R10 resumes", oc_out, 1'b1);
  endtask

  task automatic t_fault_ignored;
    wr(0, ctl(3'b011, 0, 1));
    fault_in = 1'b1;
    step(2); chk("R11 toggle despite fault", oc_out, 1'b1);
    chk("R11 no status", fault_stat, 1'b0);
    fault_in = 1'b0;
  endtask

  task automatic t_off;
    wr(0, ctl(3'b000, 0, 1));
    fault_in = 1'b1;
    step(2); step(5);
    chk("R2 low", oc_out, 1'b0);
    chk("R2 no fault", fault_stat, 1'b0);
    fault_in = 1'b0;
  endtask

  task automatic t_trigger;
    wr(0, ctl(3'b000));
    trig_in = 1'b1; @(posedge clk); @(negedge clk); trig_in = 1'b0;
    chk("R13 set", trig_stat, 1'b1);
    step(5); chk("R13 manual keeps on B match", trig_stat, 1'b1);
    wr(0, ctl(3'b000, 0, 0, 0, 1)); chk("R13 sw clear", trig_stat, 1'b0);
    wr(0, ctl(3'b000, 1));
    trig_in = 1'b1; @(posedge clk); @(negedge clk); trig_in = 1'b0;
    chk("R13 set auto", trig_stat, 1'b1);
    step(4); chk("R13 no match", trig_stat, 1'b1);
    step(5); chk("R13 auto clear", trig_stat, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_set_once;
    t_clr_once;
    t_toggle;
    t_pulse_once;
    t_pulse_cont;
    t_edge_pwm;
    t_center_pwm;
    t_fault;
    t_fault_ignored;
    t_off;
    t_trigger;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule